// File: doc/BRIEF.md
# Level-1 Trigger Energy and Timing Filter

This block condenses three linearised channel samples into one trigger primitive per bunch crossing. The three samples are added every crossing. The sum feeds two six-tap FIR filters that run side by side. One bank of coefficients is shaped to estimate deposited energy. The other bank is shaped to give a sharp maximum at the crossing that produced the pulse.

A three-point local-maximum detector watches the timing-filter stream. In the single crossing where it finds a peak, the matching energy-filter value is clamped to the output width and emitted together with a peak flag. In every other crossing the output is zero. Every path has the same fixed depth, so the trigger logic downstream can tie each result to a bunch crossing by counting cycles.

The coefficients are loaded through a simple write port, one tap per cycle. A transparent setting, with a single unit coefficient per bank, passes the delayed raw sum through. This setting is used for commissioning.

Top module: `l1_trig_filter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `energy_out` is 0 and `peak_flag` is 0. Reset clears all twelve coefficients to 0, so a pulse that arrives after reset with no new coefficients produces no flag and a zero output.
- R2: The three channel inputs are read as unsigned values and added at full width. With energy tap 0 and timing tap 0 set to 1 and all other taps set to 0, the flagged output equals the three-input sum of the peak crossing.
- R3: `peak_flag` is never high in two consecutive cycles. When it is high, the middle timing value of the three-value window is strictly greater than the older neighbour and greater than or equal to the newer neighbour.
- R4: In every cycle where `peak_flag` is low, `energy_out` is 0.
- R5: Let x(n) be the input sum sampled at clock edge n. Each filter computes y(n) = sum over k = 0..5 of c[k]·x(n−k). The result for sample n appears at the outputs right after edge n+4.
- R6: A cycle with `cfg_we` high writes `cfg_coef` (signed 8-bit) into tap `cfg_tap`. The bank is chosen by `cfg_bank`: 0 selects the energy bank and 1 selects the timing bank. The new value is used from the next edge on. A tap index of 6 or 7 changes nothing, and a write never changes the other bank.
- R7: The flagged energy value is clamped to the range 0 to 65535. A negative filter result gives 0 with the flag still high. A result above 65535 gives 65535.
- R8: On a plateau of two equal timing values, the earlier sample is flagged and the later one is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch0_in | input | 16 | Linearised sample, channel 0 (unsigned) |
| ch1_in | input | 16 | Linearised sample, channel 1 (unsigned) |
| ch2_in | input | 16 | Linearised sample, channel 2 (unsigned) |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_bank | input | 1 | 0 = energy bank, 1 = timing bank |
| cfg_tap | input | 3 | Tap index; 0 to 5 are valid |
| cfg_coef | input | 8 | Signed coefficient value |
| energy_out | output | 16 | Clamped energy, non-zero only on a flagged crossing |
| peak_flag | output | 1 | High in the crossing assigned to a pulse |

## Verification
The assertions check four things on every cycle, whatever the stimulus:
- the output is zero whenever the flag is low;
- the flag never fires twice in a row;
- a flag always sits on a window whose middle value rises above the older neighbour and does not fall below the newer one;
- the flagged value equals the clamped energy-filter result from two cycles earlier.

Other behaviours show only in the bench's scenarios:
- the overall four-cycle latency from input to output;
- the arithmetic of the adder and of the taps;
- the earlier-sample tie rule on a plateau;
- the effect of a write on one bank but not the other;
- ignored tap indices;
- coefficient clearing on reset.

// File: rtl/l1f_pkg.sv
// Shared definitions for the level-1 energy/timing filter.
// Assumes: the bank encoding is fixed by the configuration interface.
package l1f_pkg;
    // Coefficient bank selector values seen on cfg_bank.
    typedef enum logic {
        BANK_ENERGY = 1'b0,
        BANK_TIMING = 1'b1
    } bank_e;

    localparam int NUM_BANKS = 2;
endpackage

// File: rtl/l1f_fir.sv
// Six-tap (parameterised) FIR with its own coefficient registers.
// Input samples are unsigned. Coefficients are signed two's complement.
// The accumulator is sized by the parent so that it cannot overflow.
// Latency: a sample on sample_in is multiplied at tap 0 one edge after it is
// captured, and the registered sum appears one edge after that.
module l1f_fir #(
    parameter int SUM_W  = 18,
    parameter int COEF_W = 8,
    parameter int TAPS   = 6,
    parameter int TAP_AW = 3,
    parameter int ACC_W  = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [TAP_AW-1:0]        wr_tap,
    input  logic signed [COEF_W-1:0] wr_coef,
    input  logic [SUM_W-1:0]         sample_in,
    output logic signed [ACC_W-1:0]  acc_out
);
    localparam int PROD_W = SUM_W + 1 + COEF_W;

    logic [SUM_W-1:0]         line  [TAPS];
    logic signed [COEF_W-1:0] coef  [TAPS];
    logic signed [PROD_W-1:0] prod  [TAPS];
    logic signed [ACC_W-1:0]  acc_d;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        // Coefficient register: loaded when the write addresses this tap.
        always_ff @(posedge clk) begin
            if (!rst_n)
                coef[k] <= '0;
            else if (wr_en && (wr_tap == TAP_AW'(k)))
                coef[k] <= wr_coef;
        end

        // Delay line stage: tap 0 takes the new sum, others shift.
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) line[k] <= '0;
                else        line[k] <= sample_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) line[k] <= '0;
                else        line[k] <= line[k-1];
            end
        end

        // Signed product of the zero-extended sample and its coefficient.
        assign prod[k] = PROD_W'($signed({1'b0, line[k]})) * PROD_W'(coef[k]);
    end

    // Adder tree over all tap products, sign-extended to accumulator width.
    always_comb begin
        acc_d = '0;
        for (int k = 0; k < TAPS; k++)
            acc_d = acc_d + ACC_W'(prod[k]);
    end

    // Output register of the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_out <= '0;
        else        acc_out <= acc_d;
    end
endmodule

// File: rtl/l1f_peak.sv
// Three-point local-maximum detector with an aligned energy gate.
// Keeps the two previous timing values. The current timing input is the
// newer neighbour of the middle value. A peak needs middle > older and
// middle >= newer, so on a tie the earlier sample wins. The energy value that
// goes with the middle sample is delayed one stage, clamped to
// [0, 2^OUT_W-1] and passed on only in a peak cycle.
module l1f_peak #(
    parameter int ACC_W = 30,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] energy_in,
    input  logic signed [ACC_W-1:0] timing_in,
    output logic [OUT_W-1:0]        energy_out,
    output logic                    peak_flag
);
    localparam logic signed [ACC_W-1:0] OUT_MAX =
        ACC_W'((64'd1 << OUT_W) - 64'd1);

    logic signed [ACC_W-1:0] t_mid, t_old, e_mid;
    logic                    is_peak;
    logic [OUT_W-1:0]        e_clamped;

    // Timing history window and the energy sample aligned to its middle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_mid <= '0;
            t_old <= '0;
            e_mid <= '0;
        end else begin
            t_mid <= timing_in;
            t_old <= t_mid;
            e_mid <= energy_in;
        end
    end

    // Local-maximum test with the earlier-sample tie rule.
    assign is_peak = (t_mid > t_old) && (t_mid >= timing_in);

    // Clamp the energy value into the unsigned output range.
    always_comb begin
        if (e_mid < 0)
            e_clamped = '0;
        else if (e_mid > OUT_MAX)
            e_clamped = '1;
        else
            e_clamped = e_mid[OUT_W-1:0];
    end

    // Gated output register: value and flag only in a peak crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            energy_out <= '0;
            peak_flag  <= 1'b0;
        end else begin
            energy_out <= is_peak ? e_clamped : '0;
            peak_flag  <= is_peak;
        end
    end
endmodule

// File: rtl/l1_trig_filter.sv
// Level-1 trigger filter top: a three-channel adder, two parallel FIR banks
// (energy and timing) and a peak-gated output.
// Assumes the channel samples are already linearised and unsigned.
// Fixed latency: four edges from the input sample to the output.
module l1_trig_filter
    import l1f_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 8,
    parameter int TAPS     = 6,
    parameter int OUT_W    = 16,
    parameter int TAP_AW   = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SAMPLE_W-1:0]      ch0_in,
    input  logic [SAMPLE_W-1:0]      ch1_in,
    input  logic [SAMPLE_W-1:0]      ch2_in,
    input  logic                     cfg_we,
    input  logic                     cfg_bank,
    input  logic [TAP_AW-1:0]        cfg_tap,
    input  logic signed [COEF_W-1:0] cfg_coef,
    output logic [OUT_W-1:0]         energy_out,
    output logic                     peak_flag
);
    localparam int SUM_W  = SAMPLE_W + 2;
    localparam int ACC_W  = SUM_W + 1 + COEF_W + $clog2(TAPS);

    logic [SUM_W-1:0]        chan_sum;
    logic signed [ACC_W-1:0] fir_acc [NUM_BANKS];

    // Full-width sum of the three channels, one per crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) chan_sum <= '0;
        else        chan_sum <= SUM_W'(ch0_in) + SUM_W'(ch1_in) + SUM_W'(ch2_in);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        l1f_fir #(
            .SUM_W (SUM_W),
            .COEF_W(COEF_W),
            .TAPS  (TAPS),
            .TAP_AW(TAP_AW),
            .ACC_W (ACC_W)
        ) u_fir (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_bank == 1'(b))),
            .wr_tap   (cfg_tap),
            .wr_coef  (cfg_coef),
            .sample_in(chan_sum),
            .acc_out  (fir_acc[b])
        );
    end

    l1f_peak #(
        .ACC_W(ACC_W),
        .OUT_W(OUT_W)
    ) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .energy_in (fir_acc[BANK_ENERGY]),
        .timing_in (fir_acc[BANK_TIMING]),
        .energy_out(energy_out),
        .peak_flag (peak_flag)
    );
endmodule

// File: rtl/l1f_checker.sv
// Property checker for l1_trig_filter, attached by bind.
// Watches the outputs and the two filter results inside the top.
module l1f_checker #(
    parameter int ACC_W = 30,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [OUT_W-1:0]        energy_out,
    input logic                    peak_flag,
    input logic signed [ACC_W-1:0] e_acc,
    input logic signed [ACC_W-1:0] t_acc
);
    // Expected clamp of a filter value into the output range (R7).
    function automatic logic [OUT_W-1:0] clip(input logic signed [ACC_W-1:0] v);
        if (v < 0) return '0;
        if (v > ACC_W'((64'd1 << OUT_W) - 64'd1)) return '1;
        return v[OUT_W-1:0];
    endfunction

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (energy_out == '0 && !peak_flag));

    assert_gate_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_flag |-> energy_out == '0);

    assert_no_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
        peak_flag |=> !peak_flag);

    assert_peak_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        peak_flag |-> ($past(t_acc, 2) > $past(t_acc, 3)) &&
                      ($past(t_acc, 2) >= $past(t_acc, 1)));

    assert_energy_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        peak_flag |-> energy_out == clip($past(e_acc, 2)));
endmodule

bind l1_trig_filter l1f_checker #(
    .ACC_W(ACC_W),
    .OUT_W(OUT_W)
) u_l1f_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .energy_out(energy_out),
    .peak_flag (peak_flag),
    .e_acc     (fir_acc[0]),
    .t_acc     (fir_acc[1])
);

// File: tb/l1_trig_filter_bench.sv
// Directed bench: one task per scenario, each task checks its own results.
// A reference model built from the requirements predicts every output cycle.
module l1_trig_filter_bench;
    localparam int HIST = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ch0_in = '0, ch1_in = '0, ch2_in = '0;
    logic        cfg_we = 1'b0, cfg_bank = 1'b0;
    logic [2:0]  cfg_tap = '0;
    logic signed [7:0] cfg_coef = '0;
    logic [15:0] energy_out;
    logic        peak_flag;

    int     n_checks = 0, n_fail = 0, cyc = 0;
    longint xs [HIST];
    int     ce [6], ct [6];
    int     flag_cnt = 0, flag_cyc = -1;
    longint flag_energy = 0;
    bit     p_we = 0, p_bank = 0;
    int     p_tap = 0, p_val = 0;
    bit     finished = 0;

    l1_trig_filter u_l1_trig_filter (
        .clk(clk), .rst_n(rst_n),
        .ch0_in(ch0_in), .ch1_in(ch1_in), .ch2_in(ch2_in),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_tap(cfg_tap),
        .cfg_coef(cfg_coef),
        .energy_out(energy_out), .peak_flag(peak_flag)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint xv(int i);
        return (i < 0 || i >= HIST) ? 0 : xs[i];
    endfunction

    function automatic longint filt(bit timing, int j);
        longint s = 0;
        for (int k = 0; k < 6; k++)
            s += longint'(timing ? ct[k] : ce[k]) * xv(j - k);
        return s;
    endfunction

    function automatic longint clampv(longint v);
        if (v < 0) return 0;
        if (v > 65535) return 65535;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One crossing: compare outputs with the model (R4, R5), then drive inputs.
    task automatic tick(input int a, input int b, input int c, input string tag);
        int  j;
        bit  pk;
        longint ee;
        @(negedge clk);
        j  = cyc - 4;
        pk = (filt(1, j) > filt(1, j - 1)) && (filt(1, j) >= filt(1, j + 1));
        ee = pk ? clampv(filt(0, j)) : 0;
        n_checks++;
        if (energy_out !== 16'(ee) || peak_flag !== pk) begin
            n_fail++;
            $display("FAIL %s/R4/R5 cyc %0d: energy %0d flag %0b expected energy %0d flag %0b",
                     tag, cyc, energy_out, peak_flag, ee, pk);
        end
        if (peak_flag === 1'b1) begin
            flag_cnt++;
            flag_cyc    = cyc;
            flag_energy = energy_out;
        end
        ch0_in = 16'(a); ch1_in = 16'(b); ch2_in = 16'(c);
        cfg_we = p_we; cfg_bank = p_bank; cfg_tap = 3'(p_tap); cfg_coef = 8'(p_val);
        if (cyc + 1 < HIST) xs[cyc + 1] = (!rst_n) ? 0 : longint'(a) + b + c;
    endtask

    task automatic flush(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(0, 0, 0, tag);
    endtask

    task automatic set_coef(input bit bank, input int tap, input int val);
        p_we = 1; p_bank = bank; p_tap = tap; p_val = val;
        tick(0, 0, 0, "R6");
        p_we = 0;
        if (tap < 6) begin
            if (bank) ct[tap] = val;
            else      ce[tap] = val;
        end
    endtask

    task automatic load(input int e [6], input int t [6]);
        for (int k = 0; k < 6; k++) set_coef(0, k, e[k]);
        for (int k = 0; k < 6; k++) set_coef(1, k, t[k]);
        flush(3, "R6");
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(energy_out == 0 && peak_flag == 0, "R1 reset state", energy_out, 0);
        flush(6, "R1");
    endtask

    task automatic t_transparent();
        int s;
        load('{1, 0, 0, 0, 0, 0}, '{1, 0, 0, 0, 0, 0});
        flag_cnt = 0;
        tick(10, 20, 30, "R2");
        tick(100, 150, 50, "R2");
        tick(200, 250, 300, "R2");
        s = cyc + 1;
        tick(100, 100, 100, "R2");
        tick(20, 20, 20, "R2");
        flush(8, "R2");
        check(flag_cnt == 1, "R2 one flag per pulse", flag_cnt, 1);
        check(flag_energy == 750, "R2 transparent sum", flag_energy, 750);
        check(flag_cyc - s == 4, "R5 fixed latency", flag_cyc - s, 4);
    endtask

    task automatic t_fir_shape();
        load('{2, -1, 3, 0, 1, -2}, '{1, 2, 1, 0, 0, 0});
        flag_cnt = 0;
        tick(50, 0, 0, "R5");  tick(400, 10, 0, "R5"); tick(900, 30, 5, "R5");
        tick(300, 20, 1, "R5"); tick(60, 0, 0, "R5");
        flush(4, "R5");
        tick(0, 0, 700, "R5"); tick(0, 0, 1500, "R5"); tick(0, 0, 100, "R5");
        tick(0, 0, 800, "R5"); tick(0, 0, 200, "R5");
        flush(10, "R5");
        check(flag_cnt >= 2, "R5 filtered pulses flagged", flag_cnt, 2);
    endtask

    task automatic t_tie();
        int s;
        load('{1, 0, 0, 0, 0, 0}, '{1, 0, 0, 0, 0, 0});
        flag_cnt = 0;
        tick(30, 0, 0, "R8");
        tick(90, 0, 0, "R8");
        s = cyc + 1;
        tick(0, 90, 0, "R8");
        tick(30, 0, 0, "R8");
        flush(8, "R8");
        check(flag_cnt == 1, "R8 single flag on plateau", flag_cnt, 1);
        check(flag_cyc - s == 4, "R8 earlier sample flagged", flag_cyc - s, 4);
        check(flag_energy == 90, "R8 plateau energy", flag_energy, 90);
    endtask

    task automatic t_saturate();
        load('{127, 0, 0, 0, 0, 0}, '{1, 0, 0, 0, 0, 0});
        flag_cnt = 0;
        tick(65535, 65535, 65535, "R7");
        flush(8, "R7");
        check(flag_cnt == 1 && flag_energy == 65535, "R7 clamp high", flag_energy, 65535);
        load('{-3, 0, 0, 0, 0, 0}, '{1, 0, 0, 0, 0, 0});
        flag_cnt = 0;
        tick(1000, 0, 0, "R7");
        flush(8, "R7");
        check(flag_cnt == 1 && flag_energy == 0, "R7 clamp negative", flag_energy, 0);
    endtask

    task automatic t_cfg();
        load('{1, 0, 0, 0, 0, 0}, '{1, 0, 0, 0, 0, 0});
        set_coef(0, 6, 99);
        set_coef(0, 7, 99);
        set_coef(1, 0, 2);
        flush(3, "R6");
        flag_cnt = 0;
        tick(200, 200, 100, "R6");
        flush(8, "R6");
        check(flag_cnt == 1 && flag_energy == 500, "R6 stray tap and bank isolation",
              flag_energy, 500);
    endtask

    task automatic t_rereset();
        flush(4, "R1");
        rst_n = 1'b0;
        for (int k = 0; k < 6; k++) begin ce[k] = 0; ct[k] = 0; end
        flush(4, "R1");
        check(energy_out == 0 && peak_flag == 0, "R1 outputs in reset", energy_out, 0);
        rst_n = 1'b1;
        flush(2, "R1");
        flag_cnt = 0;
        tick(500, 500, 500, "R1");
        flush(8, "R1");
        check(flag_cnt == 0, "R1 coefficients cleared", flag_cnt, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) xs[i] = 0;
        for (int k = 0; k < 6; k++) begin ce[k] = 0; ct[k] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_transparent();
        t_fir_shape();
        t_tie();
        t_saturate();
        t_cfg();
        t_rereset();
        summary();
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule